// File: doc/BRIEF.md
# Indirect Configuration Address/Data Port Bridge

This block gives a host I/O bus indirect access to a per-function configuration register space. Software first writes a 32-bit target address into an address latch port. It then reads or writes one of four byte-wide data ports. The block decodes the latch into bus, device, function and dword-register fields. The data port's low address bits are added to the register offset. The host transfer, of one, two or four bytes, is turned into a run of single-byte accesses on a register-file interface. For reads, the returned bytes are packed back into one little-endian word.

An access runs only when the latch has its enable bit set and selects bus zero. A present-device map decides whether the addressed device and function exist. This map holds an installed-slot count, a per-slot occupancy mask and a per-slot highest-function value. If the gate or the presence test fails, no register-file access is made: a read returns all ones and a write is dropped.

The sequencer has three states. SEQ_IDLE accepts a host request. On a blocked access or any latch access it moves to SEQ_DONE (the "finish" transition). On a valid data access it moves to SEQ_ISSUE (the "launch" transition). SEQ_ISSUE drives one byte request per cycle. It stays there on each acknowledged byte that is not the last ("step"), and on an acknowledge that is still pending ("wait"). It moves to SEQ_DONE on the last acknowledged byte ("complete"). SEQ_DONE pulses the done output for one cycle and returns to SEQ_IDLE ("release").

Top module: `cfg_port_bridge`

## Requirements
- R1: A host write with host_port[2]=0 loads host_wdata into the 32-bit address latch. A host read with host_port[2]=0 returns exactly the value last written, with done one cycle after acceptance.
- R2: A data access (host_port[2]=1) is carried out only when latch bit 31 is 1 and latch bits 23:16 are zero. Otherwise a read returns 32'hFFFFFFFF, a write produces no register request, and done follows one cycle after acceptance.
- R3: The first byte register index is {latch[7:2],2'b00} plus host_port[1:0]. The device is latch[15:11] and the function is latch[10:8]. Each following byte uses the next index, wrapping modulo 256.
- R4: host_size 0 gives one byte access, 1 gives two and 2 or 3 give four. For writes, byte n carries host_wdata[8n+7:8n] to index base+n, and the bytes are issued in ascending order.
- R5: For reads, the byte read at base+n lands in host_rdata[8n+7:8n], and the bytes above the transfer size read as zero.
- R6: The target is absent when the device is not below dev_installed, when its slot_fill bit is 0, or when the function exceeds that device's 3-bit field fn_top[3*dev+2:3*dev]. An absent read returns 32'hFFFFFFFF, and an absent write makes no register request.
- R7: Byte requests follow on consecutive cycles while cfg_ack answers in the same cycle. With a zero-wait acknowledge, an n-byte access raises host_done n+1 cycles after acceptance, for exactly one cycle.
- R8: A host request that arrives while host_busy is high is ignored, including an address-latch write.
- R9: Reset clears the address latch to zero, so a data-port read right after reset returns 32'hFFFFFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_req | input | 1 | Host access request, sampled in idle |
| host_we | input | 1 | 1 = write, 0 = read |
| host_port | input | 3 | Bit 2: 0 = address latch, 1 = data port; bits 1:0 = data lane |
| host_size | input | 2 | Transfer size code (0 = byte, 1 = word, 2/3 = dword) |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, valid while host_done |
| host_done | output | 1 | One-cycle completion pulse |
| host_busy | output | 1 | Access in progress |
| cfg_req | output | 1 | Byte request to register file |
| cfg_we | output | 1 | Byte request is a write |
| cfg_dev | output | 5 | Target device |
| cfg_fn | output | 3 | Target function |
| cfg_reg | output | 8 | Target byte register index |
| cfg_wdata | output | 8 | Byte write data |
| cfg_ack | input | 1 | Register file accepts the current byte |
| cfg_rdata | input | 8 | Byte read data, valid with cfg_ack |
| dev_installed | input | 6 | Number of installed device slots |
| slot_fill | input | 32 | Per-slot occupancy |
| fn_top | input | 96 | Per-slot highest function number, 3 bits each |

## Verification
Each host access is launched at a falling edge, and the bench counts the falling edges after the accepting rising edge until host_done appears. The count must be 1 for latch accesses and blocked or absent targets, and n+1 for an n-byte transfer served by the zero-wait register model. host_rdata is sampled in the same falling-edge window as host_done. Written bytes are recorded by a monitor at each acknowledged write edge, and their number, order, indices and data are compared once done has been seen.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_ISSUE = 2'd1,
        SEQ_DONE  = 2'd2
    } seq_state_e;

    localparam int unsigned LATCH_W = 32;
    localparam int unsigned DEV_W   = 5;
    localparam int unsigned FN_W    = 3;
    localparam int unsigned REG_W   = 8;

    // index of the last byte of a transfer, from the host size code
    function automatic logic [1:0] last_byte_idx(input logic [1:0] size_code);
        unique case (size_code)
            2'd0:    return 2'd0;
            2'd1:    return 2'd1;
            default: return 2'd3;
        endcase
    endfunction

endpackage

// File: rtl/cfg_addr_latch.sv
module cfg_addr_latch
    import cfgp_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [LATCH_W-1:0]  wr_data,
    output logic [LATCH_W-1:0]  latch_q,
    output logic [DEV_W-1:0]    dev,
    output logic [FN_W-1:0]     fn,
    output logic [REG_W-1:0]    reg_base,
    output logic                gate_open
);

    always_ff @(posedge clk) begin
        if (!rst_n)
            latch_q <= '0;
        else if (wr_en)
            latch_q <= wr_data;
    end

    always_comb begin
        dev       = latch_q[15:11];
        fn        = latch_q[10:8];
        reg_base  = {latch_q[7:2], 2'b00};
        gate_open = latch_q[31] && (latch_q[23:16] == 8'h00);
    end

    // R1: the latch changes only through a host write
    a_r1_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(latch_q));

endmodule

// File: rtl/cfg_target_check.sv
module cfg_target_check
    import cfgp_pkg::*;
#(
    parameter int unsigned NDEV = 32
) (
    input  logic [DEV_W-1:0]      dev,
    input  logic [FN_W-1:0]       fn,
    input  logic [DEV_W:0]        dev_installed,
    input  logic [NDEV-1:0]       slot_fill,
    input  logic [NDEV*FN_W-1:0]  fn_top,
    output logic                  present
);

    localparam int unsigned SEL_W = (NDEV > 1) ? $clog2(NDEV) : 1;

    logic [FN_W-1:0] fn_lim [NDEV];

    generate
        for (genvar g = 0; g < NDEV; g++) begin : g_lim
            assign fn_lim[g] = fn_top[g*FN_W +: FN_W];
        end
    endgenerate

    logic [DEV_W:0]  dev_ext;
    logic [SEL_W-1:0] sel;
    logic             in_table;

    always_comb begin
        dev_ext  = {1'b0, dev};
        sel      = dev_ext[SEL_W-1:0];
        in_table = (dev_ext < (DEV_W+1)'(NDEV));
        present  = in_table
                && (dev_ext < dev_installed)
                && slot_fill[sel]
                && (fn <= fn_lim[sel]);
    end

endmodule

// File: rtl/cfg_byte_seq.sv
module cfg_byte_seq
    import cfgp_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                host_req,
    input  logic                host_we,
    input  logic [2:0]          host_port,
    input  logic [1:0]          host_size,
    input  logic [31:0]         host_wdata,
    output logic [31:0]         host_rdata,
    output logic                host_done,
    output logic                host_busy,
    input  logic [LATCH_W-1:0]  latch_q,
    input  logic [REG_W-1:0]    reg_base,
    input  logic                gate_open,
    input  logic                present,
    output logic                latch_wr,
    output logic                cfg_req,
    output logic                cfg_we,
    output logic [REG_W-1:0]    cfg_reg,
    output logic [7:0]          cfg_wdata,
    input  logic                cfg_ack,
    input  logic [7:0]          cfg_rdata
);

    seq_state_e state, state_nx;

    logic [1:0]        byte_idx;
    logic [1:0]        last_idx;
    logic [REG_W-1:0]  reg_cur;
    logic [31:0]       wbuf;
    logic [31:0]       rbuf;
    logic              op_we;

    logic is_latch;
    logic launch;

    assign is_latch = !host_port[2];
    assign launch   = !is_latch && gate_open && present;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= SEQ_IDLE;
        else
            state <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            SEQ_IDLE: begin
                if (host_req)
                    state_nx = launch ? SEQ_ISSUE : SEQ_DONE;
            end
            SEQ_ISSUE: begin
                if (cfg_ack && (byte_idx == last_idx))
                    state_nx = SEQ_DONE;
            end
            SEQ_DONE: state_nx = SEQ_IDLE;
            default:  state_nx = SEQ_IDLE;
        endcase
    end

    // datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            byte_idx <= '0;
            last_idx <= '0;
            reg_cur  <= '0;
            wbuf     <= '0;
            rbuf     <= '0;
            op_we    <= 1'b0;
        end else begin
            unique case (state)
                SEQ_IDLE: begin
                    if (host_req) begin
                        if (is_latch) begin
                            if (!host_we)
                                rbuf <= latch_q;
                        end else if (launch) begin
                            reg_cur  <= reg_base + REG_W'(host_port[1:0]);
                            byte_idx <= 2'd0;
                            last_idx <= last_byte_idx(host_size);
                            wbuf     <= host_wdata;
                            rbuf     <= '0;
                            op_we    <= host_we;
                        end else begin
                            rbuf <= 32'hFFFF_FFFF;
                        end
                    end
                end
                SEQ_ISSUE: begin
                    if (cfg_ack) begin
                        if (!op_we)
                            rbuf[{byte_idx, 3'b000} +: 8] <= cfg_rdata;
                        wbuf     <= wbuf >> 8;
                        reg_cur  <= reg_cur + 1'b1;
                        byte_idx <= byte_idx + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        cfg_req    = 1'b0;
        host_done  = 1'b0;
        host_busy  = 1'b1;
        latch_wr   = 1'b0;
        unique case (state)
            SEQ_IDLE: begin
                host_busy = 1'b0;
                latch_wr  = host_req && host_we && is_latch;
            end
            SEQ_ISSUE: cfg_req   = 1'b1;
            SEQ_DONE:  host_done = 1'b1;
            default: ;
        endcase
        cfg_we     = op_we;
        cfg_reg    = reg_cur;
        cfg_wdata  = wbuf[7:0];
        host_rdata = rbuf;
    end

    // R2 / R6: no register request without an open gate and a present target
    a_r2_req_gated: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_req |-> (gate_open && present));

    // R7: done is a single-cycle pulse
    a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        host_done |=> !host_done);

    // R3 / R7: a non-final acknowledged byte is followed at once by the next index
    a_r3_next_index: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_req && cfg_ack && (byte_idx != last_idx))
            |=> (cfg_req && (cfg_reg == $past(cfg_reg) + 8'd1)));

    // R8: a request seen while busy does not start a latch write
    a_r8_busy_ignore: assert property (@(posedge clk) disable iff (!rst_n)
        host_busy |-> !latch_wr);

    // R7: done follows the final acknowledged byte in the next cycle
    a_r7_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_req && cfg_ack && (byte_idx == last_idx)) |=> host_done);

endmodule

// File: rtl/cfg_port_bridge.sv
module cfg_port_bridge
    import cfgp_pkg::*;
#(
    parameter int unsigned NDEV = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_req,
    input  logic              host_we,
    input  logic [2:0]        host_port,
    input  logic [1:0]        host_size,
    input  logic [31:0]       host_wdata,
    output logic [31:0]       host_rdata,
    output logic              host_done,
    output logic              host_busy,
    output logic              cfg_req,
    output logic              cfg_we,
    output logic [4:0]        cfg_dev,
    output logic [2:0]        cfg_fn,
    output logic [7:0]        cfg_reg,
    output logic [7:0]        cfg_wdata,
    input  logic              cfg_ack,
    input  logic [7:0]        cfg_rdata,
    input  logic [5:0]        dev_installed,
    input  logic [NDEV-1:0]   slot_fill,
    input  logic [NDEV*3-1:0] fn_top
);

    logic [LATCH_W-1:0] latch_q;
    logic [DEV_W-1:0]   dev;
    logic [FN_W-1:0]    fn;
    logic [REG_W-1:0]   reg_base;
    logic               gate_open;
    logic               present;
    logic               latch_wr;

    cfg_addr_latch u_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (latch_wr),
        .wr_data   (host_wdata),
        .latch_q   (latch_q),
        .dev       (dev),
        .fn        (fn),
        .reg_base  (reg_base),
        .gate_open (gate_open)
    );

    cfg_target_check #(.NDEV(NDEV)) u_target (
        .dev           (dev),
        .fn            (fn),
        .dev_installed (dev_installed),
        .slot_fill     (slot_fill),
        .fn_top        (fn_top),
        .present       (present)
    );

    cfg_byte_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_req   (host_req),
        .host_we    (host_we),
        .host_port  (host_port),
        .host_size  (host_size),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .host_done  (host_done),
        .host_busy  (host_busy),
        .latch_q    (latch_q),
        .reg_base   (reg_base),
        .gate_open  (gate_open),
        .present    (present),
        .latch_wr   (latch_wr),
        .cfg_req    (cfg_req),
        .cfg_we     (cfg_we),
        .cfg_reg    (cfg_reg),
        .cfg_wdata  (cfg_wdata),
        .cfg_ack    (cfg_ack),
        .cfg_rdata  (cfg_rdata)
    );

    assign cfg_dev = dev;
    assign cfg_fn  = fn;

endmodule

// File: tb/cfg_port_bridge_bench.sv
module cfg_port_bridge_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_req = 1'b0;
    logic        host_we = 1'b0;
    logic [2:0]  host_port = 3'd0;
    logic [1:0]  host_size = 2'd0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        host_done, host_busy;
    logic        cfg_req, cfg_we;
    logic [4:0]  cfg_dev;
    logic [2:0]  cfg_fn;
    logic [7:0]  cfg_reg, cfg_wdata;
    logic        cfg_ack;
    logic [7:0]  cfg_rdata;
    logic [5:0]  dev_installed = 6'd5;
    logic [31:0] slot_fill = 32'h0000_0017;
    logic [95:0] fn_top = '0;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    cfg_port_bridge u_cfg_port_bridge (
        .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_we(host_we),
        .host_port(host_port), .host_size(host_size), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .host_done(host_done), .host_busy(host_busy),
        .cfg_req(cfg_req), .cfg_we(cfg_we), .cfg_dev(cfg_dev), .cfg_fn(cfg_fn),
        .cfg_reg(cfg_reg), .cfg_wdata(cfg_wdata), .cfg_ack(cfg_ack),
        .cfg_rdata(cfg_rdata), .dev_installed(dev_installed),
        .slot_fill(slot_fill), .fn_top(fn_top)
    );

    function automatic logic [7:0] model_byte(input logic [4:0] d, input logic [2:0] f,
                                              input logic [7:0] r);
        return r ^ {d, f} ^ 8'h5A;
    endfunction

    // zero-wait register file model
    assign cfg_ack   = cfg_req;
    assign cfg_rdata = model_byte(cfg_dev, cfg_fn, cfg_reg);

    // write monitor
    int          wtotal = 0;
    logic [7:0]  wl_reg [8];
    logic [7:0]  wl_dat [8];
    always @(posedge clk) begin
        if (cfg_req && cfg_ack && cfg_we) begin
            wl_reg[wtotal % 8] <= cfg_reg;
            wl_dat[wtotal % 8] <= cfg_wdata;
            wtotal <= wtotal + 1;
        end
    end

    function automatic logic [2:0] fn_limit(input int d);
        case (d)
            1: return 3'd2;
            2: return 3'd7;
            4: return 3'd1;
            default: return 3'd0;
        endcase
    endfunction

    function automatic bit exp_open(input logic [31:0] a);
        return a[31] && (a[23:16] == 8'h00);
    endfunction

    function automatic bit exp_present(input logic [31:0] a);
        int d;
        d = int'(a[15:11]);
        return (d < 5) && (d != 3) && (a[10:8] <= fn_limit(d));
    endfunction

    function automatic int nbytes(input logic [1:0] s);
        return (s == 2'd0) ? 1 : (s == 2'd1) ? 2 : 4;
    endfunction

    function automatic logic [31:0] exp_read(input logic [31:0] a, input logic [1:0] lane,
                                             input logic [1:0] s);
        logic [31:0] v;
        logic [7:0]  r;
        if (!exp_open(a) || !exp_present(a)) return 32'hFFFF_FFFF;
        v = '0;
        for (int k = 0; k < nbytes(s); k++) begin
            r = {a[7:2], 2'b00} + 8'(lane) + 8'(k);
            v[k*8 +: 8] = model_byte(a[15:11], a[10:8], r);
        end
        return v;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic access(input logic [2:0] p, input logic we, input logic [1:0] sz,
                          input logic [31:0] wd, output logic [31:0] rd, output int cyc);
        @(negedge clk);
        host_req = 1'b1; host_we = we; host_port = p; host_size = sz; host_wdata = wd;
        @(posedge clk);
        @(negedge clk);
        host_req = 1'b0;
        cyc = 1;
        while (!host_done && cyc < 40) begin
            @(negedge clk);
            cyc++;
        end
        rd = host_rdata;
    endtask

    // data read with value and latency checks
    task automatic data_read(input logic [31:0] a, input logic [1:0] lane, input logic [1:0] sz,
                             input string req);
        logic [31:0] rd, ex;
        int cyc, ecyc;
        ex = exp_read(a, lane, sz);
        ecyc = (exp_open(a) && exp_present(a)) ? nbytes(sz) + 1 : 1;
        access({1'b1, lane}, 1'b0, sz, 32'h0, rd, cyc);
        check(rd == ex, req, "read data", rd, ex);
        check(cyc == ecyc, "R7", "read latency", cyc, ecyc);
    endtask

    task automatic data_write(input logic [31:0] a, input logic [1:0] lane, input logic [1:0] sz,
                              input logic [31:0] wd, input string req);
        logic [31:0] rd;
        int cyc, start, n;
        bit live;
        live  = exp_open(a) && exp_present(a);
        n     = live ? nbytes(sz) : 0;
        start = wtotal;
        access({1'b1, lane}, 1'b1, sz, wd, rd, cyc);
        check(wtotal - start == n, req, "write byte count", wtotal - start, n);
        check(cyc == (live ? n + 1 : 1), "R7", "write latency", cyc, live ? n + 1 : 1);
        for (int k = 0; k < n && k < 4; k++) begin
            logic [7:0] er;
            er = {a[7:2], 2'b00} + 8'(lane) + 8'(k);
            check(wl_reg[(start + k) % 8] == er, "R3", "write index",
                  {24'h0, wl_reg[(start + k) % 8]}, {24'h0, er});
            check(wl_dat[(start + k) % 8] == wd[k*8 +: 8], "R4", "write byte",
                  {24'h0, wl_dat[(start + k) % 8]}, {24'h0, wd[k*8 +: 8]});
        end
    endtask

    task automatic set_latch(input logic [31:0] a);
        logic [31:0] rd;
        int cyc;
        access(3'd0, 1'b1, 2'd2, a, rd, cyc);
    endtask

    task automatic latch_check(input logic [31:0] ex, input string req);
        logic [31:0] rd;
        int cyc;
        access(3'd0, 1'b0, 2'd2, 32'h0, rd, cyc);
        check(rd == ex, req, "latch readback", rd, ex);
        check(cyc == 1, "R1", "latch latency", cyc, 1);
    endtask

    function automatic logic [31:0] mk(input bit en, input logic [7:0] bus, input logic [4:0] d,
                                       input logic [2:0] f, input logic [5:0] idx);
        return {en, 7'h00, bus, d, f, idx, 2'b00};
    endfunction

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] a, rd;
        int cyc;
        fn_top[1*3 +: 3] = 3'd2;
        fn_top[2*3 +: 3] = 3'd7;
        fn_top[4*3 +: 3] = 3'd1;
        void'($urandom(32'd2024));

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R9: reset state
        check(host_busy == 1'b0 && host_done == 1'b0, "R9", "idle after reset",
              {30'h0, host_busy, host_done}, 32'h0);
        latch_check(32'h0, "R9");
        data_read(32'h0, 2'd0, 2'd2, "R9");

        // R1: latch write and readback
        a = mk(1'b1, 8'h00, 5'd1, 3'd2, 6'h04);
        set_latch(a);
        latch_check(a, "R1");

        // R5: dword, word, byte reads
        data_read(a, 2'd0, 2'd2, "R5");
        data_read(a, 2'd2, 2'd1, "R5");
        data_read(a, 2'd3, 2'd0, "R3");

        // R4: writes
        data_write(a, 2'd3, 2'd0, 32'h0000_00AB, "R4");
        data_write(a, 2'd0, 2'd2, 32'hDEAD_BEEF, "R4");
        data_write(a, 2'd1, 2'd3, 32'h1234_5678, "R4");

        // R2: gate closed or bus nonzero
        a = mk(1'b0, 8'h00, 5'd1, 3'd2, 6'h04);
        set_latch(a);
        data_read(a, 2'd0, 2'd2, "R2");
        data_write(a, 2'd0, 2'd2, 32'h1111_1111, "R2");
        a = mk(1'b1, 8'h01, 5'd1, 3'd2, 6'h04);
        set_latch(a);
        data_read(a, 2'd1, 2'd1, "R2");
        data_write(a, 2'd0, 2'd0, 32'h22, "R2");

        // R6: absent targets
        a = mk(1'b1, 8'h00, 5'd3, 3'd0, 6'h00); set_latch(a);
        data_read(a, 2'd0, 2'd2, "R6");
        data_write(a, 2'd0, 2'd2, 32'h3333_3333, "R6");
        a = mk(1'b1, 8'h00, 5'd6, 3'd0, 6'h00); set_latch(a);
        data_read(a, 2'd0, 2'd2, "R6");
        a = mk(1'b1, 8'h00, 5'd1, 3'd3, 6'h00); set_latch(a);
        data_read(a, 2'd0, 2'd2, "R6");
        a = mk(1'b1, 8'h00, 5'd4, 3'd1, 6'h00); set_latch(a);
        data_read(a, 2'd0, 2'd1, "R6");

        // R3: index wrap
        a = mk(1'b1, 8'h00, 5'd2, 3'd7, 6'h3F); set_latch(a);
        data_read(a, 2'd3, 2'd2, "R3");
        data_write(a, 2'd3, 2'd2, 32'hCAFE_F00D, "R3");

        // R8: request during busy ignored
        a = mk(1'b1, 8'h00, 5'd0, 3'd0, 6'h10); set_latch(a);
        @(negedge clk);
        host_req = 1'b1; host_we = 1'b0; host_port = 3'b100; host_size = 2'd2;
        @(posedge clk);
        @(negedge clk);
        host_we = 1'b1; host_port = 3'b000; host_wdata = 32'h0;
        @(negedge clk);
        host_req = 1'b0;
        cyc = 2;
        while (!host_done && cyc < 40) begin @(negedge clk); cyc++; end
        rd = host_rdata;
        check(rd == exp_read(a, 2'd0, 2'd2), "R8", "read during ignored request",
              rd, exp_read(a, 2'd0, 2'd2));
        latch_check(a, "R8");

        // random accesses
        for (int i = 0; i < 150; i++) begin
            logic [1:0] lane, sz;
            logic [7:0] bus;
            bit en;
            en  = ($urandom % 8) != 0;
            bus = (($urandom % 6) == 0) ? 8'($urandom) : 8'h00;
            a   = mk(en, bus, 5'($urandom % 8), 3'($urandom % 8), 6'($urandom));
            lane = 2'($urandom);
            sz   = 2'($urandom);
            set_latch(a);
            if ($urandom % 2)
                data_read(a, lane, sz, "R5");
            else
                data_write(a, lane, sz, $urandom, "R4");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule